// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Converter Code Register

This block is the digital front end of a 14-bit digital-to-analog converter whose host bus is only eight bits wide. A host writes the code in two byte writes, one to an upper staging register and one to a lower staging register. A separate transfer write then commits both halves to the output register in one step, so the converter never sees a half-updated code. Several converters sharing a transfer address can therefore change their outputs on the same clock edge.

A fourth address bypasses the double buffering. In that mode the bus byte goes into both staging registers and into the output register in a single write. This is mainly used to force zero or full scale quickly during calibration. Everything is sampled on a system clock. A command takes effect on each rising edge at which select and write are both low. A one-cycle pulse marks every edge at which the output register was loaded.

Top module: `dac_byte_loader`

## Requirements
- R1: While `sel_n` is high at a clock edge, neither staging register nor `code_out` changes, and `upd_pulse` is low after that edge.
- R2: While `wr_n` is high at a clock edge, no register changes and `upd_pulse` is low after that edge.
- R3: Address 2'b01 with select and write low loads bus bits 5..0 into the upper staging half, which feeds code bits 13..8. Bus bits 7..6 are dropped, and `code_out` does not change.
- R4: Address 2'b10 with select and write low loads bus bits 7..0 into the lower staging half, which feeds code bits 7..0. `code_out` does not change.
- R5: Address 2'b11 with select and write low copies {upper half, lower half} into `code_out` on that edge. The bus value is ignored, and the staging registers keep their contents.
- R6: Address 2'b00 with select and write low writes the bus into both staging halves and into `code_out` on that edge. `code_out[13:8]` takes bus bits 5..0 and `code_out[7:0]` takes bus bits 7..0.
- R7: A synchronous active-high `rst` clears both staging halves and `code_out` to zero and holds `upd_pulse` low.
- R8: `upd_pulse` is high for exactly the cycle after each edge that loaded `code_out` (address 2'b00 or 2'b11 with select and write low), and is low otherwise.
- R9: A write held low over several edges repeats its command on each edge. The result is the same code, with `upd_pulse` high after every one of those edges.
- R10: The code is straight binary. Staging 6'h20 and 8'h00 and then transferring gives 14'h2000, the mid-scale value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Command select: 00 pass-through, 01 upper, 10 lower, 11 transfer |
| bus_din | input | BUS_W (8) | Host data byte |
| code_out | output | CODE_W (14) | Converter code, straight binary |
| upd_pulse | output | 1 | One-cycle marker of an output register load |

## Verification
The bench builds the block with its default widths, an 8-bit bus and a 14-bit code. This leaves the upper half six bits wide, so an upper write with bits 7..6 set shows directly whether those bits are dropped. It also lets the pass-through mode put the low six bus bits into the code twice. Writes suppressed by select or by strobe are followed by transfers, which brings the untouched staging contents out to the port. Held strobes, a reset in the middle of a sequence and a mid-scale code are covered by directed tests.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    typedef enum logic [1:0] {
        CMD_THRU = 2'b00,
        CMD_HI   = 2'b01,
        CMD_LO   = 2'b10,
        CMD_XFER = 2'b11
    } cmd_e;

    typedef struct packed {
        logic ld_hi;
        logic ld_lo;
        logic ld_out;
        logic out_from_bus;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{ld_hi: 1'b0, ld_lo: 1'b0, ld_out: 1'b0, out_from_bus: 1'b0};

    function automatic ctl_t decode_cmd(input logic active, input cmd_e cmd);
        ctl_t c;
        c = CTL_IDLE;
        if (active) begin
            unique case (cmd)
                CMD_THRU: c = '{ld_hi: 1'b1, ld_lo: 1'b1, ld_out: 1'b1, out_from_bus: 1'b1};
                CMD_HI:   c.ld_hi = 1'b1;
                CMD_LO:   c.ld_lo = 1'b1;
                CMD_XFER: c.ld_out = 1'b1;
                default:  c = CTL_IDLE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dacld_decode.sv
module dacld_decode
    import dacld_pkg::*;
(
    input  logic       sel_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output ctl_t       ctl
);
    logic active;
    cmd_e cmd;

    always_comb begin
        active = !sel_n && !wr_n;
        cmd    = cmd_e'(addr);
        ctl    = decode_cmd(active, cmd);
    end
endmodule

// File: rtl/dacld_stage.sv
module dacld_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/dacld_outreg.sv
module dacld_outreg
    import dacld_pkg::*;
#(
    parameter int HI_W = 6,
    parameter int LO_W = 8,
    localparam int CW  = HI_W + LO_W
) (
    input  logic            clk,
    input  logic            rst,
    input  ctl_t            ctl,
    input  logic [HI_W-1:0] bus_hi,
    input  logic [LO_W-1:0] bus_lo,
    input  logic [HI_W-1:0] st_hi,
    input  logic [LO_W-1:0] st_lo,
    output logic [CW-1:0]   code,
    output logic            pulse
);
    logic [CW-1:0] next_code;

    always_comb begin
        if (ctl.out_from_bus)
            next_code = {bus_hi, bus_lo};
        else
            next_code = {st_hi, st_lo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= ctl.ld_out;
            if (ctl.ld_out)
                code <= next_code;
        end
    end
endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
    import dacld_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [BUS_W-1:0]  bus_din,
    output logic [CODE_W-1:0] code_out,
    output logic              upd_pulse
);
    localparam int HI_W = CODE_W - BUS_W;
    localparam int LO_W = BUS_W;

    ctl_t            ctl;
    logic [HI_W-1:0] st_hi;
    logic [LO_W-1:0] st_lo;
    logic [HI_W-1:0] bus_hi;

    assign bus_hi = bus_din[HI_W-1:0];

    dacld_decode u_dec (
        .sel_n (sel_n),
        .wr_n  (wr_n),
        .addr  (addr),
        .ctl   (ctl)
    );

    generate
        if (HI_W > 0 && HI_W <= BUS_W) begin : g_stages
            dacld_stage #(.W(HI_W)) u_hi (
                .clk (clk),
                .rst (rst),
                .en  (ctl.ld_hi),
                .d   (bus_hi),
                .q   (st_hi)
            );
            dacld_stage #(.W(LO_W)) u_lo (
                .clk (clk),
                .rst (rst),
                .en  (ctl.ld_lo),
                .d   (bus_din),
                .q   (st_lo)
            );
        end else begin : g_bad_widths
            $error("CODE_W must exceed BUS_W and be at most twice BUS_W");
        end
    endgenerate

    dacld_outreg #(.HI_W(HI_W), .LO_W(LO_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .bus_hi (bus_hi),
        .bus_lo (bus_din),
        .st_hi  (st_hi),
        .st_lo  (st_lo),
        .code   (code_out),
        .pulse  (upd_pulse)
    );
endmodule

// File: rtl/dacld_chk.sv
module dacld_chk #(
    parameter int BUS_W  = 8,
    parameter int CODE_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              wr_n,
    input logic [1:0]        addr,
    input logic [BUS_W-1:0]  bus_din,
    input logic [CODE_W-1:0] code_out,
    input logic              upd_pulse
);
    localparam int HI_W = CODE_W - BUS_W;

    logic go;
    assign go = !sel_n && !wr_n;

    AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> ($stable(code_out) && !upd_pulse)); // R1

    AST_STROBE_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> ($stable(code_out) && !upd_pulse)); // R2

    AST_UPPER_LOAD_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
        (go && addr == 2'b01) |=> $stable(code_out)); // R3

    AST_LOWER_LOAD_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
        (go && addr == 2'b10) |=> $stable(code_out)); // R4

    AST_XFER_MARKS: assert property (@(posedge clk) disable iff (rst)
        (go && addr == 2'b11) |=> upd_pulse); // R5

    AST_THRU_VALUE: assert property (@(posedge clk) disable iff (rst)
        (go && addr == 2'b00) |=> (code_out == {$past(bus_din[HI_W-1:0]), $past(bus_din)})); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (code_out == '0 && !upd_pulse)); // R7

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> $past(go && (addr == 2'b00 || addr == 2'b11))); // R8

endmodule

bind dac_byte_loader dacld_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .bus_din   (bus_din),
    .code_out  (code_out),
    .upd_pulse (upd_pulse)
);

// File: tb/test_dac_byte_loader.sv
module test_dac_byte_loader;
    localparam int BUS_W  = 8;
    localparam int CODE_W = 14;

    typedef struct packed {
        logic        sel_n;
        logic        wr_n;
        logic [1:0]  addr;
        logic [7:0]  data;
        logic [13:0] code;
        logic        pulse;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 2'b11, 8'hAA, 14'h0000, 1'b1}, // 0  R5 transfer of cleared halves
        '{1'b0, 1'b0, 2'b01, 8'hFF, 14'h0000, 1'b0}, // 1  R3 upper, R8 pulse drops
        '{1'b0, 1'b0, 2'b10, 8'h5A, 14'h0000, 1'b0}, // 2  R4 lower
        '{1'b1, 1'b0, 2'b11, 8'h00, 14'h0000, 1'b0}, // 3  R1 deselected
        '{1'b0, 1'b1, 2'b11, 8'h00, 14'h0000, 1'b0}, // 4  R2 strobe high
        '{1'b0, 1'b0, 2'b11, 8'h00, 14'h3F5A, 1'b1}, // 5  R5 bus ignored
        '{1'b0, 1'b0, 2'b01, 8'hC5, 14'h3F5A, 1'b0}, // 6  R3 bits 7..6 dropped
        '{1'b0, 1'b0, 2'b11, 8'hFF, 14'h055A, 1'b1}, // 7  R5
        '{1'b0, 1'b0, 2'b00, 8'hFF, 14'h3FFF, 1'b1}, // 8  R6 full scale
        '{1'b0, 1'b0, 2'b00, 8'h00, 14'h0000, 1'b1}, // 9  R6 zero
        '{1'b0, 1'b0, 2'b11, 8'hFF, 14'h0000, 1'b1}, // 10 R6 staging also written
        '{1'b0, 1'b0, 2'b00, 8'h81, 14'h0181, 1'b1}, // 11 R6
        '{1'b0, 1'b0, 2'b11, 8'h00, 14'h0181, 1'b1}, // 12 R6 staging holds pass-through
        '{1'b1, 1'b0, 2'b00, 8'hFF, 14'h0181, 1'b0}, // 13 R1
        '{1'b0, 1'b1, 2'b01, 8'h3F, 14'h0181, 1'b0}, // 14 R2
        '{1'b0, 1'b0, 2'b11, 8'h00, 14'h0181, 1'b1}, // 15 R2 staging untouched
        '{1'b0, 1'b0, 2'b10, 8'h00, 14'h0181, 1'b0}, // 16 R4
        '{1'b0, 1'b0, 2'b01, 8'h20, 14'h0181, 1'b0}, // 17 R3
        '{1'b0, 1'b0, 2'b11, 8'h00, 14'h2000, 1'b1}  // 18 R10 mid-scale
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              sel_n;
    logic              wr_n;
    logic [1:0]        addr;
    logic [BUS_W-1:0]  bus_din;
    logic [CODE_W-1:0] code_out;
    logic              upd_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dac_byte_loader #(.BUS_W(BUS_W), .CODE_W(CODE_W)) i_dac_byte_loader (
        .clk       (clk),
        .rst       (rst),
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .bus_din   (bus_din),
        .code_out  (code_out),
        .upd_pulse (upd_pulse)
    );

    task automatic check(input string req, input logic [13:0] exp_code, input logic exp_pulse);
        n_chk++;
        if (code_out !== exp_code || upd_pulse !== exp_pulse) begin
            n_fail++;
            $display("FAIL %s: code=%h pulse=%b expected code=%h pulse=%b",
                     req, code_out, upd_pulse, exp_code, exp_pulse);
        end
    endtask

    task automatic drive(input logic s, input logic w, input logic [1:0] a, input logic [7:0] d);
        sel_n   = s;
        wr_n    = w;
        addr    = a;
        bus_din = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b1, 1'b1, 2'b00, 8'h00);
        repeat (3) @(negedge clk);
        check("R7 reset state", 14'h0000, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].sel_n, VEC[i].wr_n, VEC[i].addr, VEC[i].data);
            step();
            check($sformatf("vector %0d", i), VEC[i].code, VEC[i].pulse);
        end

        drive(1'b1, 1'b1, 2'b00, 8'h00);
        step();
        check("R8 no pulse when idle", 14'h2000, 1'b0);

        // R9: pass-through held for three edges
        drive(1'b0, 1'b0, 2'b00, 8'h3C);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 held write repeats", 14'h3C3C, 1'b1);
        end
        drive(1'b1, 1'b1, 2'b00, 8'h00);
        step();
        check("R9 pulse ends with strobe", 14'h3C3C, 1'b0);

        // R7: reset in mid-sequence clears staging too
        drive(1'b0, 1'b0, 2'b01, 8'h15);
        step();
        drive(1'b0, 1'b0, 2'b10, 8'h77);
        step();
        drive(1'b1, 1'b1, 2'b00, 8'h00);
        rst = 1'b1;
        step();
        check("R7 reset clears output", 14'h0000, 1'b0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 2'b11, 8'hFF);
        step();
        check("R7 reset cleared staging", 14'h0000, 1'b1);

        // R4: lower-only write then transfer
        drive(1'b0, 1'b0, 2'b10, 8'hE3);
        step();
        check("R4 output unchanged", 14'h0000, 1'b0);
        drive(1'b0, 1'b0, 2'b11, 8'h00);
        step();
        check("R4 lower half lands in bits 7..0", 14'h00E3, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule